// File: doc/BRIEF.md
# Configuration Mailbox and Save-Region Decoder

This block holds the cartridge configuration state for a memory-emulation controller. That state is made up of three switch bits: one that maps SDRAM into the cartridge space, one that lets the cartridge side write SDRAM, and one that enables the disk drive. It also holds a save-memory type, a security-chip type and a video-standard type. Two agents can change the state. The first is a host that issues a request through a mailbox. The second is a packet framer that writes a configuration entry directly, one cycle at a time.

A host request carries a command byte and two 32-bit arguments. While the request is handled, the block raises a busy flag. When busy drops, two 32-bit response words are ready. For the configuration command (byte 0x43), argument 0 selects a configuration entry and argument 1 gives its value. Writing the save type also recomputes two things: a save-region byte offset, measured down from the top of a memory whose size is a parameter, and the enable bits for battery RAM, banked RAM and flash.

Top module: `cfg_mailbox_regs`

## Requirements
- R1: After reset, the outputs are as follows: save type 0, save offset 0, all three enable bits low, all three switch bits low, security-chip type 0xFFFF, video type 0xFF, busy low, and both response words 0.
- R2: A `host_req` seen while busy is low does three things on that edge: it latches the command and both arguments and raises busy. Processing takes one cycle, and busy clears on the following edge. With no conflict, busy is high for exactly 2 cycles.
- R3: A `host_req` seen while busy is high is ignored. The response belongs to the request that set busy.
- R4: For command 0x43, the response words are read after the update. Word 0 is {16'h0, save_type, 5'b0, dd_enable, sdram_writable, sdram_switch}. Word 1 is {8'h0, video_type, chip_type}.
- R5: A command other than 0x43 returns 0xFFFFFFFF in both response words and changes no configuration state.
- R6: Entries 0, 1 and 2 set `sdram_switch`, `sdram_writable` and `dd_enable` respectively. The bit is set when the value is nonzero and cleared when the value is zero.
- R7: Entry 4 loads the security-chip type from value bits [15:0]. Entry 5 loads the video type from value bits [7:0].
- R8: Entry 3 loads the save type from value bits [7:0]. Any valid type first clears all enable bits. The types map as follows, with MEM the memory size in bytes:
  - 0: offset 0, no enable bit.
  - 1: MEM-512, no enable bit.
  - 2: MEM-2048, no enable bit.
  - 3: MEM-32768, with `sram_en`.
  - 4: MEM-262144, with `flash_en`.
  - 5: MEM-98304, with `sram_en` and `sram_banked`.
  - 6: offset 0x01608000, with `flash_en`.
- R9: A save type above 6 leaves the save type, the offset and the enable bits unchanged.
- R10: An entry number above 5 changes no state.
- R11: When a framer write and a mailbox configuration write fall in the same cycle, the framer write is applied first. The mailbox write is applied one cycle later, so its value is the one that remains. This stretches busy to 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host request strobe |
| host_cmd | input | 8 | Host command byte |
| host_arg0 | input | 32 | Host argument 0 (entry number) |
| host_arg1 | input | 32 | Host argument 1 (entry value) |
| mbx_busy | output | 1 | Mailbox busy flag |
| mbx_rsp0 | output | 32 | Response word 0 |
| mbx_rsp1 | output | 32 | Response word 1 |
| fr_we | input | 1 | Framer configuration write strobe |
| fr_id | input | 32 | Framer entry number |
| fr_val | input | 32 | Framer entry value |
| sdram_switch | output | 1 | SDRAM mapped into cartridge space |
| sdram_writable | output | 1 | SDRAM writable from cartridge side |
| dd_enable | output | 1 | Disk-drive enable |
| sram_en | output | 1 | Battery RAM save enabled |
| sram_banked | output | 1 | Banked RAM save layout |
| flash_en | output | 1 | Flash save enabled |
| save_type | output | 8 | Current save type |
| save_offset | output | OFF_W | Save-region byte offset |
| chip_type | output | 16 | Security-chip type |
| video_type | output | 8 | Video-standard type |

## Verification
Two things can fall in the same cycle: a direct framer write and the mailbox's own configuration write, which the mailbox issues in its processing cycle. The bench provokes the clash by driving a framer write to entry 4 in exactly the cycle after a host request is seen. The host request targets the same entry with a different value. The bench then judges three things: busy must last 3 cycles instead of 2, the security-chip type must end at the mailbox's value, and response word 1 must carry that value.

// File: rtl/cfgmb_pkg.sv
// Shared types and constants of the configuration mailbox.
// Assumes entry numbers and command bytes are fixed by the host protocol.
package cfgmb_pkg;
    typedef enum logic [1:0] {
        MB_IDLE  = 2'd0,
        MB_EXEC  = 2'd1,
        MB_REPLY = 2'd2
    } mb_state_t;

    localparam logic [7:0]  CMD_CONFIG   = 8'h43;
    localparam logic [31:0] ENT_SWITCH   = 32'd0;
    localparam logic [31:0] ENT_WRITABLE = 32'd1;
    localparam logic [31:0] ENT_DISK     = 32'd2;
    localparam logic [31:0] ENT_SAVE     = 32'd3;
    localparam logic [31:0] ENT_CHIP     = 32'd4;
    localparam logic [31:0] ENT_VIDEO    = 32'd5;

    typedef struct packed {
        logic flash;
        logic banked;
        logic sram;
    } save_en_t;
endpackage

// File: rtl/save_region_dec.sv
// Decodes a save-type code into a region offset and enable bits.
// Assumes MEM_BYTES covers the largest region; offsets are in bytes.
module save_region_dec
    import cfgmb_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 32'h0400_0000,
    parameter int unsigned OFF_W     = $clog2(MEM_BYTES)
) (
    input  logic [7:0]       sel,
    output logic             valid,
    output logic [OFF_W-1:0] offset,
    output save_en_t         en
);
    localparam int unsigned FIXED_FLASH_OFF = 32'h0160_8000;

    // Combinational map from type code to region and enables.
    always_comb begin
        valid  = 1'b1;
        offset = '0;
        en     = '0;
        case (sel)
            8'd0: ;
            8'd1: offset = OFF_W'(MEM_BYTES - 32'd512);
            8'd2: offset = OFF_W'(MEM_BYTES - 32'd2048);
            8'd3: begin
                offset  = OFF_W'(MEM_BYTES - 32'd32768);
                en.sram = 1'b1;
            end
            8'd4: begin
                offset   = OFF_W'(MEM_BYTES - 32'd262144);
                en.flash = 1'b1;
            end
            8'd5: begin
                offset    = OFF_W'(MEM_BYTES - 32'd98304);
                en.sram   = 1'b1;
                en.banked = 1'b1;
            end
            8'd6: begin
                offset   = OFF_W'(FIXED_FLASH_OFF);
                en.flash = 1'b1;
            end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_state_regs.sv
// Configuration state registers with a two-source write port.
// Assumes at most one framer and one mailbox write per cycle; framer wins.
module cfg_state_regs
    import cfgmb_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 32'h0400_0000,
    parameter int unsigned OFF_W     = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fr_we,
    input  logic [31:0]      fr_id,
    input  logic [31:0]      fr_val,
    input  logic             mb_we,
    input  logic [31:0]      mb_id,
    input  logic [31:0]      mb_val,
    output logic             mb_ack,
    output logic             sdram_switch,
    output logic             sdram_writable,
    output logic             dd_enable,
    output save_en_t         save_en,
    output logic [7:0]       save_type,
    output logic [OFF_W-1:0] save_offset,
    output logic [15:0]      chip_type,
    output logic [7:0]       video_type
);
    logic             wr_en;
    logic [31:0]      wr_id;
    logic [31:0]      wr_val;
    logic             dec_valid;
    logic [OFF_W-1:0] dec_offset;
    save_en_t         dec_en;

    // Select the write source: framer has priority over mailbox.
    always_comb begin
        wr_en  = fr_we | mb_we;
        wr_id  = fr_we ? fr_id  : mb_id;
        wr_val = fr_we ? fr_val : mb_val;
        mb_ack = mb_we & ~fr_we;
    end

    save_region_dec #(.MEM_BYTES(MEM_BYTES), .OFF_W(OFF_W)) u_dec (
        .sel    (wr_val[7:0]),
        .valid  (dec_valid),
        .offset (dec_offset),
        .en     (dec_en)
    );

    // Apply the selected write to the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdram_switch   <= 1'b0;
            sdram_writable <= 1'b0;
            dd_enable      <= 1'b0;
            save_en        <= '0;
            save_type      <= 8'd0;
            save_offset    <= '0;
            chip_type      <= 16'hFFFF;
            video_type     <= 8'hFF;
        end else if (wr_en) begin
            case (wr_id)
                ENT_SWITCH:   sdram_switch   <= |wr_val;
                ENT_WRITABLE: sdram_writable <= |wr_val;
                ENT_DISK:     dd_enable      <= |wr_val;
                ENT_SAVE: if (dec_valid) begin
                    save_type   <= wr_val[7:0];
                    save_offset <= dec_offset;
                    save_en     <= dec_en;
                end
                ENT_CHIP:     chip_type      <= wr_val[15:0];
                ENT_VIDEO:    video_type     <= wr_val[7:0];
                default: ;
            endcase
        end
    end

    // R11
    fr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_we && mb_we && fr_id == ENT_CHIP) |=> chip_type == $past(fr_val[15:0]));

    // R9
    bad_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_id == ENT_SAVE && !dec_valid) |=>
            ($stable(save_type) && $stable(save_offset) && $stable(save_en)));

    // R8
    banked_sram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_en.banked |-> save_en.sram);
endmodule

// File: rtl/mbx_ctrl.sv
// Host mailbox sequencer: latch request, issue update, build response.
// Assumes the host holds off a new request until busy clears.
module mbx_ctrl
    import cfgmb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic [7:0]  host_cmd,
    input  logic [31:0] host_arg0,
    input  logic [31:0] host_arg1,
    input  logic        mb_ack,
    input  logic [2:0]  st_bits,
    input  logic [7:0]  save_type,
    input  logic [15:0] chip_type,
    input  logic [7:0]  video_type,
    output logic        busy,
    output logic [31:0] rsp0,
    output logic [31:0] rsp1,
    output logic        mb_we,
    output logic [31:0] mb_id,
    output logic [31:0] mb_val
);
    mb_state_t   state;
    logic [7:0]  cmd_q;
    logic [31:0] arg0_q;
    logic [31:0] arg1_q;
    logic        is_cfg;

    // Decode the latched command and present the write request.
    always_comb begin
        is_cfg = (cmd_q == CMD_CONFIG);
        mb_we  = (state == MB_EXEC) && is_cfg;
        mb_id  = arg0_q;
        mb_val = arg1_q;
    end

    // Sequence one request from latch through response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= MB_IDLE;
            busy   <= 1'b0;
            cmd_q  <= 8'd0;
            arg0_q <= 32'd0;
            arg1_q <= 32'd0;
            rsp0   <= 32'd0;
            rsp1   <= 32'd0;
        end else begin
            case (state)
                MB_IDLE: if (host_req) begin
                    busy   <= 1'b1;
                    cmd_q  <= host_cmd;
                    arg0_q <= host_arg0;
                    arg1_q <= host_arg1;
                    state  <= MB_EXEC;
                end
                MB_EXEC: if (!is_cfg || mb_ack) state <= MB_REPLY;
                MB_REPLY: begin
                    if (is_cfg) begin
                        rsp0 <= {16'h0, save_type, 5'h0, st_bits};
                        rsp1 <= {8'h0, video_type, chip_type};
                    end else begin
                        rsp0 <= 32'hFFFF_FFFF;
                        rsp1 <= 32'hFFFF_FFFF;
                    end
                    busy  <= 1'b0;
                    state <= MB_IDLE;
                end
                default: state <= MB_IDLE;
            endcase
        end
    end

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !busy) |=> busy);

    // R2
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MB_REPLY) |=> !busy);

    // R3
    hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_req) |=> ($stable(cmd_q) && $stable(arg1_q)));

    // R5
    rsp_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MB_REPLY && !is_cfg) |=> (rsp0 == 32'hFFFF_FFFF && rsp1 == 32'hFFFF_FFFF));

    // R11
    defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_we && !mb_ack) |=> (state == MB_EXEC));
endmodule

// File: rtl/cfg_mailbox_regs.sv
// Top: host mailbox plus configuration state and save-region decoder.
// Assumes a single clock domain; the framer and the host share it.
module cfg_mailbox_regs
    import cfgmb_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 32'h0400_0000,
    parameter int unsigned OFF_W     = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic [7:0]       host_cmd,
    input  logic [31:0]      host_arg0,
    input  logic [31:0]      host_arg1,
    output logic             mbx_busy,
    output logic [31:0]      mbx_rsp0,
    output logic [31:0]      mbx_rsp1,
    input  logic             fr_we,
    input  logic [31:0]      fr_id,
    input  logic [31:0]      fr_val,
    output logic             sdram_switch,
    output logic             sdram_writable,
    output logic             dd_enable,
    output logic             sram_en,
    output logic             sram_banked,
    output logic             flash_en,
    output logic [7:0]       save_type,
    output logic [OFF_W-1:0] save_offset,
    output logic [15:0]      chip_type,
    output logic [7:0]       video_type
);
    logic        mb_we;
    logic        mb_ack;
    logic [31:0] mb_id;
    logic [31:0] mb_val;
    save_en_t    save_en;

    // Break out the enable struct onto plain ports.
    always_comb begin
        sram_en     = save_en.sram;
        sram_banked = save_en.banked;
        flash_en    = save_en.flash;
    end

    mbx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_cmd   (host_cmd),
        .host_arg0  (host_arg0),
        .host_arg1  (host_arg1),
        .mb_ack     (mb_ack),
        .st_bits    ({dd_enable, sdram_writable, sdram_switch}),
        .save_type  (save_type),
        .chip_type  (chip_type),
        .video_type (video_type),
        .busy       (mbx_busy),
        .rsp0       (mbx_rsp0),
        .rsp1       (mbx_rsp1),
        .mb_we      (mb_we),
        .mb_id      (mb_id),
        .mb_val     (mb_val)
    );

    cfg_state_regs #(.MEM_BYTES(MEM_BYTES), .OFF_W(OFF_W)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .fr_we          (fr_we),
        .fr_id          (fr_id),
        .fr_val         (fr_val),
        .mb_we          (mb_we),
        .mb_id          (mb_id),
        .mb_val         (mb_val),
        .mb_ack         (mb_ack),
        .sdram_switch   (sdram_switch),
        .sdram_writable (sdram_writable),
        .dd_enable      (dd_enable),
        .save_en        (save_en),
        .save_type      (save_type),
        .save_offset    (save_offset),
        .chip_type      (chip_type),
        .video_type     (video_type)
    );
endmodule

// File: tb/cfg_mailbox_regs_test.sv
module cfg_mailbox_regs_test;
    localparam int VW = 110;
    // {entry8, value32, type8, offset32, en3{flash,banked,sram}, st3{dd,wr,sw}, chip16, video8}
    localparam logic [VW-1:0] VECS [15] = '{
        {8'd3, 32'd1,          8'd1, 32'h03FF_FE00, 3'b000, 3'b000, 16'hFFFF, 8'hFF},
        {8'd3, 32'd3,          8'd3, 32'h03FF_8000, 3'b001, 3'b000, 16'hFFFF, 8'hFF},
        {8'd3, 32'd5,          8'd5, 32'h03FE_8000, 3'b011, 3'b000, 16'hFFFF, 8'hFF},
        {8'd3, 32'd4,          8'd4, 32'h03FC_0000, 3'b100, 3'b000, 16'hFFFF, 8'hFF},
        {8'd3, 32'd6,          8'd6, 32'h0160_8000, 3'b100, 3'b000, 16'hFFFF, 8'hFF},
        {8'd3, 32'd9,          8'd6, 32'h0160_8000, 3'b100, 3'b000, 16'hFFFF, 8'hFF},
        {8'd3, 32'h102,        8'd2, 32'h03FF_F800, 3'b000, 3'b000, 16'hFFFF, 8'hFF},
        {8'd3, 32'd0,          8'd0, 32'h0000_0000, 3'b000, 3'b000, 16'hFFFF, 8'hFF},
        {8'd0, 32'd5,          8'd0, 32'h0000_0000, 3'b000, 3'b001, 16'hFFFF, 8'hFF},
        {8'd1, 32'd1,          8'd0, 32'h0000_0000, 3'b000, 3'b011, 16'hFFFF, 8'hFF},
        {8'd2, 32'h8000_0000,  8'd0, 32'h0000_0000, 3'b000, 3'b111, 16'hFFFF, 8'hFF},
        {8'd1, 32'd0,          8'd0, 32'h0000_0000, 3'b000, 3'b101, 16'hFFFF, 8'hFF},
        {8'd4, 32'h1234_5678,  8'd0, 32'h0000_0000, 3'b000, 3'b101, 16'h5678, 8'hFF},
        {8'd5, 32'h0000_0ABC,  8'd0, 32'h0000_0000, 3'b000, 3'b101, 16'h5678, 8'hBC},
        {8'd7, 32'd1,          8'd0, 32'h0000_0000, 3'b000, 3'b101, 16'h5678, 8'hBC}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic [7:0]  host_cmd = 8'd0;
    logic [31:0] host_arg0 = 32'd0;
    logic [31:0] host_arg1 = 32'd0;
    logic        mbx_busy;
    logic [31:0] mbx_rsp0, mbx_rsp1;
    logic        fr_we = 1'b0;
    logic [31:0] fr_id = 32'd0;
    logic [31:0] fr_val = 32'd0;
    logic        sdram_switch, sdram_writable, dd_enable;
    logic        sram_en, sram_banked, flash_en;
    logic [7:0]  save_type;
    logic [25:0] save_offset;
    logic [15:0] chip_type;
    logic [7:0]  video_type;

    int n_vec = 0;
    int n_bad = 0;
    int busy_cnt;

    always #10ns clk = ~clk;

    cfg_mailbox_regs uut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_cmd(host_cmd), .host_arg0(host_arg0), .host_arg1(host_arg1),
        .mbx_busy(mbx_busy), .mbx_rsp0(mbx_rsp0), .mbx_rsp1(mbx_rsp1),
        .fr_we(fr_we), .fr_id(fr_id), .fr_val(fr_val),
        .sdram_switch(sdram_switch), .sdram_writable(sdram_writable), .dd_enable(dd_enable),
        .sram_en(sram_en), .sram_banked(sram_banked), .flash_en(flash_en),
        .save_type(save_type), .save_offset(save_offset),
        .chip_type(chip_type), .video_type(video_type)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // mode 0: plain, 1: framer entry 4 clash with cval, 2: second request while busy
    task automatic mbox(input logic [7:0] cmd, input logic [31:0] a0, input logic [31:0] a1,
                        input int mode, input logic [31:0] cval);
        @(negedge clk);
        host_req = 1'b1; host_cmd = cmd; host_arg0 = a0; host_arg1 = a1;
        @(negedge clk);
        host_req = 1'b0;
        if (mode == 1) begin fr_we = 1'b1; fr_id = 32'd4; fr_val = cval; end
        if (mode == 2) begin host_req = 1'b1; host_cmd = 8'h51; host_arg0 = 32'd5; host_arg1 = cval; end
        busy_cnt = 0;
        while (mbx_busy && busy_cnt < 10) begin
            busy_cnt++;
            @(negedge clk);
            fr_we = 1'b0;
            host_req = 1'b0;
        end
    endtask

    initial begin
        #(20ns * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {save_type, 6'(save_offset), flash_en, sram_banked, sram_en,
                     dd_enable, sdram_writable, sdram_switch, chip_type, video_type, mbx_busy},
                    {8'd0, 6'd0, 3'b000, 3'b000, 16'hFFFF, 8'hFF, 1'b0});
        check("R1", {mbx_rsp0, mbx_rsp1, 32'(save_offset)}, {32'd0, 32'd0, 32'd0});

        // vector table through the framer port: R6 R7 R8 R9 R10
        for (int i = 0; i < 15; i++) begin
            logic [VW-1:0] v;
            string tag;
            v = VECS[i];
            @(negedge clk);
            fr_we = 1'b1; fr_id = {24'd0, v[109:102]}; fr_val = v[101:70];
            @(negedge clk);
            fr_we = 1'b0;
            case (v[109:102])
                8'd0, 8'd1, 8'd2: tag = "R6";
                8'd3: tag = (v[77:70] > 8'd6) ? "R9" : "R8";
                8'd4, 8'd5: tag = "R7";
                default: tag = "R10";
            endcase
            check(tag, {save_type, 32'(save_offset), flash_en, sram_banked, sram_en,
                        dd_enable, sdram_writable, sdram_switch, chip_type, video_type},
                       {v[69:0]});
        end

        // R4 configuration command via mailbox, R2 busy length
        mbox(8'h43, 32'd3, 32'd3, 0, 32'd0);
        check("R2", 128'(busy_cnt), 128'd2);
        check("R4", {mbx_rsp0, mbx_rsp1}, {32'h0000_0305, 32'h00BC_5678});
        check("R8", {sram_en, 32'(save_offset)}, {1'b1, 32'h03FF_8000});

        // R5 non-config command
        mbox(8'h51, 32'd0, 32'd0, 0, 32'd0);
        check("R5", {mbx_rsp0, mbx_rsp1}, {32'hFFFF_FFFF, 32'hFFFF_FFFF});
        check("R5", {sdram_switch, 128'(busy_cnt)}, {1'b1, 128'd2});

        // R11 clash with framer on entry 4
        mbox(8'h43, 32'd4, 32'h2222, 1, 32'h1111);
        check("R11", 128'(busy_cnt), 128'd3);
        check("R11", {chip_type, mbx_rsp1}, {16'h2222, 32'h00BC_2222});

        // R3 second request while busy ignored
        mbox(8'h43, 32'd5, 32'h11, 2, 32'h22);
        check("R3", {mbx_rsp0, video_type}, {32'h0000_0305, 8'h11});
        check("R3", 128'(busy_cnt), 128'd2);
        repeat (3) @(negedge clk);
        check("R3", {mbx_busy, video_type}, {1'b0, 8'h11});

        // R9 unknown save type via mailbox
        mbox(8'h43, 32'd3, 32'd7, 0, 32'd0);
        check("R9", {save_type, 32'(save_offset), mbx_rsp0}, {8'd3, 32'h03FF_8000, 32'h0000_0305});

        // R1 reset again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1", {chip_type, video_type, save_type, sram_en, sdram_switch},
                    {16'hFFFF, 8'hFF, 8'd0, 1'b0, 1'b0});

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule